// File: doc/BRIEF.md
# Selection Response Gate

This block sits beside the bus phase logic of a parallel-bus storage controller. It makes two decisions. The first is whether a SELECTION phase seen on the bus is answered with the controller acting as target, or whether a RESELECTION phase is answered with the controller acting as initiator. The second is whether the controller's own Select command begins with an arbitration phase or goes straight to selection.

The answer is decided once, on the cycle the phase-detect strobe is high. That decision takes into account the role enables, the arbitration enable, the halt and diagnostic flags, the ID-match flag and the ID parity flag. It is then held until the phase-complete input arrives, so clearing an enable late does not withdraw an answer that has already been given.

A small sequencer runs the Select command. It raises an arbitration request or a selection request, and it reports a lost arbitration through a flag that stays set.

Top module: `sel_resp_gate`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, ans_tgt, ans_init, req_arb, req_sel and arb_lost_flag are all 0.
- R2: ph_det high with ph_kind=0 (selection), id_match=1, id_perr=0, cfg_tgt_en=1, and cfg_halt and cfg_diag both 0, sets ans_tgt to 1 from the cycle after the strobe.
- R3: ph_det with ph_kind=1 (reselection), under the same ID and flag conditions as R2, sets ans_init only if both cfg_init_en and cfg_arb_en are 1. If cfg_arb_en is 0, no answer is given whatever cfg_init_en is. ans_tgt and ans_init are never high together.
- R4: If id_perr=1 or id_match=0 on the strobe cycle, no answer is given.
- R5: If cfg_halt or cfg_diag is 1 on the strobe cycle, no answer is given. cfg_halt high at any time clears every output on the next cycle.
- R6: Once an answer is latched, it stays high until ph_done. It drops on the cycle after ph_done. Clearing a role enable, or a new ph_det, has no effect on it while it is held.
- R7: With cfg_arb_en=1, an accepted cmd_sel raises req_arb on the next cycle. arb_won then moves req_arb to req_sel on the next cycle. req_sel drops on the cycle after ph_done.
- R8: With cfg_arb_en=0, an accepted cmd_sel raises req_sel on the next cycle, and req_arb stays 0.
- R9: arb_lost while req_arb is high drops req_arb on the next cycle and sets arb_lost_flag. The flag stays set until the next accepted cmd_sel or cfg_halt. If arb_won and arb_lost arrive together, arb_lost takes precedence.
- R10: cmd_sel is ignored while cfg_halt is 1 or while req_arb or req_sel is high. req_arb and req_sel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_halt | input | 1 | Controller held in reset and detached from the bus |
| cfg_diag | input | 1 | Diagnostic mode, detached from the bus |
| cfg_arb_en | input | 1 | Arbitration allowed |
| cfg_tgt_en | input | 1 | Answer selection as target |
| cfg_init_en | input | 1 | Answer reselection as initiator |
| ph_det | input | 1 | One-cycle strobe: a selection-type phase was detected |
| ph_kind | input | 1 | 0 = selection, 1 = reselection |
| id_match | input | 1 | Own ID found on the data bus |
| id_perr | input | 1 | Parity error on the ID byte |
| ph_done | input | 1 | Current phase or command has completed |
| cmd_sel | input | 1 | One-cycle Select command strobe |
| arb_won | input | 1 | Arbitration won |
| arb_lost | input | 1 | Arbitration lost |
| ans_tgt | output | 1 | Answering as target |
| ans_init | output | 1 | Answering as initiator |
| req_arb | output | 1 | Arbitration phase requested |
| req_sel | output | 1 | Selection phase requested |
| arb_lost_flag | output | 1 | Last arbitration attempt was lost |

## Verification
Every output is one register stage from the inputs. A strobe, a completion, a win, a loss or a halt applied in one cycle therefore shows on the outputs just after the next rising edge. The driver applies each stimulus on a falling edge and queues the full expected output vector for that next edge. The monitor compares the queued vector one time unit after that rising edge, so each result is checked in exactly the cycle it is due. Holding cycles queue the unchanged vector, which shows that late enable changes and repeated strobes leave the outputs alone.

// File: rtl/sel_resp_pkg.sv
package sel_resp_pkg;

    typedef enum logic {
        KIND_SEL   = 1'b0,
        KIND_RESEL = 1'b1
    } ph_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARB  = 2'd1,
        SEQ_SEL  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic held;
        logic tgt;
        logic init;
    } resp_t;

    typedef struct packed {
        seq_st_e st;
        logic    lost;
    } seq_t;

endpackage

// File: rtl/sel_resp_latch.sv
module sel_resp_latch
    import sel_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_halt,
    input  logic cfg_diag,
    input  logic cfg_arb_en,
    input  logic cfg_tgt_en,
    input  logic cfg_init_en,
    input  logic ph_det,
    input  logic ph_kind,
    input  logic id_match,
    input  logic id_perr,
    input  logic ph_done,
    output logic ans_tgt,
    output logic ans_init
);

    resp_t resp_d, resp_q;
    logic  id_ok;
    logic  is_resel;

    always_comb begin
        id_ok    = !cfg_halt && !cfg_diag && id_match && !id_perr;
        is_resel = (ph_kind_e'(ph_kind) == KIND_RESEL);
        resp_d   = resp_q;
        if (!resp_q.held) begin
            if (ph_det) begin
                resp_d.tgt  = id_ok && !is_resel && cfg_tgt_en;
                resp_d.init = id_ok && is_resel && cfg_init_en && cfg_arb_en;
                resp_d.held = resp_d.tgt || resp_d.init;
            end
        end else if (ph_done) begin
            resp_d = '0;
        end
        if (cfg_halt) begin
            resp_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign ans_tgt  = resp_q.tgt;
    assign ans_init = resp_q.init;

endmodule

// File: rtl/sel_cmd_seq.sv
module sel_cmd_seq
    import sel_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_halt,
    input  logic cfg_arb_en,
    input  logic cmd_sel,
    input  logic arb_won,
    input  logic arb_lost,
    input  logic ph_done,
    output logic req_arb,
    output logic req_sel,
    output logic arb_lost_flag
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (cmd_sel) begin
                    seq_d.lost = 1'b0;
                    seq_d.st   = cfg_arb_en ? SEQ_ARB : SEQ_SEL;
                end
            end
            SEQ_ARB: begin
                if (arb_lost) begin
                    seq_d.st   = SEQ_IDLE;
                    seq_d.lost = 1'b1;
                end else if (arb_won) begin
                    seq_d.st = SEQ_SEL;
                end
            end
            SEQ_SEL: begin
                if (ph_done) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
        if (cfg_halt) begin
            seq_d.st   = SEQ_IDLE;
            seq_d.lost = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, lost: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_arb       = (seq_q.st == SEQ_ARB);
    assign req_sel       = (seq_q.st == SEQ_SEL);
    assign arb_lost_flag = seq_q.lost;

endmodule

// File: rtl/sel_resp_gate.sv
module sel_resp_gate
    import sel_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_halt,
    input  logic cfg_diag,
    input  logic cfg_arb_en,
    input  logic cfg_tgt_en,
    input  logic cfg_init_en,
    input  logic ph_det,
    input  logic ph_kind,
    input  logic id_match,
    input  logic id_perr,
    input  logic ph_done,
    input  logic cmd_sel,
    input  logic arb_won,
    input  logic arb_lost,
    output logic ans_tgt,
    output logic ans_init,
    output logic req_arb,
    output logic req_sel,
    output logic arb_lost_flag
);

    sel_resp_latch u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_halt    (cfg_halt),
        .cfg_diag    (cfg_diag),
        .cfg_arb_en  (cfg_arb_en),
        .cfg_tgt_en  (cfg_tgt_en),
        .cfg_init_en (cfg_init_en),
        .ph_det      (ph_det),
        .ph_kind     (ph_kind),
        .id_match    (id_match),
        .id_perr     (id_perr),
        .ph_done     (ph_done),
        .ans_tgt     (ans_tgt),
        .ans_init    (ans_init)
    );

    sel_cmd_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_halt      (cfg_halt),
        .cfg_arb_en    (cfg_arb_en),
        .cmd_sel       (cmd_sel),
        .arb_won       (arb_won),
        .arb_lost      (arb_lost),
        .ph_done       (ph_done),
        .req_arb       (req_arb),
        .req_sel       (req_sel),
        .arb_lost_flag (arb_lost_flag)
    );

endmodule

// File: rtl/sel_resp_gate_chk.sv
module sel_resp_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_halt,
    input logic cfg_diag,
    input logic cfg_arb_en,
    input logic cfg_tgt_en,
    input logic cfg_init_en,
    input logic ph_det,
    input logic ph_kind,
    input logic id_match,
    input logic id_perr,
    input logic ph_done,
    input logic cmd_sel,
    input logic arb_won,
    input logic arb_lost,
    input logic ans_tgt,
    input logic ans_init,
    input logic req_arb,
    input logic req_sel,
    input logic arb_lost_flag
);

    assert_tgt_clean_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ans_tgt) |-> $past(ph_det && id_match && !id_perr && !ph_kind && cfg_tgt_en && !cfg_diag));

    assert_init_needs_arb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ans_init) |-> $past(ph_det && ph_kind && cfg_arb_en && cfg_init_en && id_match && !id_perr));

    assert_one_role_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ans_tgt && ans_init));

    assert_hold_tgt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_tgt && !ph_done && !cfg_halt) |=> ans_tgt);

    assert_hold_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_init && !ph_done && !cfg_halt) |=> ans_init);

    assert_halt_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_halt |=> !(ans_tgt || ans_init || req_arb || req_sel || arb_lost_flag));

    assert_arb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && cfg_arb_en && !cfg_halt && !req_arb && !req_sel) |=> req_arb);

    assert_direct_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && !cfg_arb_en && !cfg_halt && !req_arb && !req_sel) |=> (req_sel && !req_arb));

    assert_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_arb && arb_lost && !cfg_halt) |=> (arb_lost_flag && !req_arb && !req_sel));

    assert_seq_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_arb && req_sel));

endmodule

bind sel_resp_gate sel_resp_gate_chk chk_i (.*);

// File: tb/sel_resp_gate_tb_top.sv
module sel_resp_gate_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_halt = 0, cfg_diag = 0, cfg_arb_en = 1, cfg_tgt_en = 1, cfg_init_en = 1;
    logic ph_det = 0, ph_kind = 0, id_match = 1, id_perr = 0, ph_done = 0;
    logic cmd_sel = 0, arb_won = 0, arb_lost = 0;
    logic ans_tgt, ans_init, req_arb, req_sel, arb_lost_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [4:0] exp;
        string      rq;
    } item_t;

    item_t sb[$];
    item_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    sel_resp_gate dut_i (.*);

    function automatic logic [4:0] outs();
        return {ans_tgt, ans_init, req_arb, req_sel, arb_lost_flag};
    endfunction

    // Driver: inputs were set at a falling edge; queue the vector due after the next rising edge.
    task automatic tick(input logic [4:0] exp, input string rq);
        item_t it;
        it.exp = exp;
        it.rq  = rq;
        sb.push_back(it);
        @(negedge clk);
        ph_det = 0; ph_done = 0; cmd_sel = 0; arb_won = 0; arb_lost = 0;
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (outs() !== cur.exp) begin
                errors++;
                $display("FAIL %s actual %b expected %b {tgt,init,arb,sel,lost}", cur.rq, outs(), cur.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (outs() !== 5'b0) begin
            errors++;
            $display("FAIL R1 actual %b expected %b", outs(), 5'b0);
        end
        rst_n = 1;
        tick(5'b00000, "R1 after reset");

        // R2 target answer, R6 holding
        ph_det = 1; ph_kind = 0;        tick(5'b10000, "R2 target answer");
        tick(5'b10000, "R6 held");
        cfg_tgt_en = 0;                 tick(5'b10000, "R6 late enable clear");
        ph_det = 1; ph_kind = 1;        tick(5'b10000, "R6 strobe while held");
        ph_done = 1;                    tick(5'b00000, "R6 release on done");
        cfg_tgt_en = 1;
        ph_det = 1; ph_kind = 0; cfg_tgt_en = 0; tick(5'b00000, "R2 target disabled");
        cfg_tgt_en = 1;

        // R3 initiator answer
        ph_det = 1; ph_kind = 1;        tick(5'b01000, "R3 initiator answer");
        ph_done = 1;                    tick(5'b00000, "R6 initiator release");
        cfg_arb_en = 0;
        ph_det = 1; ph_kind = 1;        tick(5'b00000, "R3 no arbitration blocks reselect");
        cfg_arb_en = 1; cfg_init_en = 0;
        ph_det = 1; ph_kind = 1;        tick(5'b00000, "R3 reselect disabled");
        cfg_init_en = 1;

        // R4 ID checks
        id_perr = 1; ph_det = 1; ph_kind = 0; tick(5'b00000, "R4 parity error");
        id_perr = 0; id_match = 0; ph_det = 1; tick(5'b00000, "R4 no id match");
        id_match = 1;

        // R5 halt and diagnostic
        cfg_diag = 1; ph_det = 1; ph_kind = 0; tick(5'b00000, "R5 diag blocks");
        cfg_diag = 0; cfg_halt = 1; ph_det = 1; tick(5'b00000, "R5 halt blocks");
        cfg_halt = 0; ph_det = 1;       tick(5'b10000, "R5 answer before halt");
        cfg_halt = 1;                   tick(5'b00000, "R5 halt clears answer");
        cfg_halt = 0;

        // R7 arbitration path
        cmd_sel = 1;                    tick(5'b00100, "R7 arbitration request");
        tick(5'b00100, "R7 waiting for win");
        arb_won = 1;                    tick(5'b00010, "R7 win moves to select");
        cmd_sel = 1;                    tick(5'b00010, "R10 command while busy");
        ph_done = 1;                    tick(5'b00000, "R7 select done");

        // R9 lost arbitration
        cmd_sel = 1;                    tick(5'b00100, "R9 arbitration request");
        arb_lost = 1; arb_won = 1;      tick(5'b00001, "R9 lost wins over won");
        tick(5'b00001, "R9 flag sticky");

        // R8 direct selection
        cfg_arb_en = 0; cmd_sel = 1;    tick(5'b00010, "R8 direct select, flag cleared");
        ph_done = 1;                    tick(5'b00000, "R8 select done");
        cfg_arb_en = 1;

        // R10 halt blocks command, halt aborts arbitration
        cfg_halt = 1; cmd_sel = 1;      tick(5'b00000, "R10 command while halted");
        cfg_halt = 0; cmd_sel = 1;      tick(5'b00100, "R10 accepted after halt");
        cfg_halt = 1;                   tick(5'b00000, "R5 halt aborts arbitration");
        cfg_halt = 0;                   tick(5'b00000, "R10 idle after halt");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule